// File: doc/BRIEF.md
# Byte-Serial Boot Stream Loader

This block turns a little-endian byte stream from a serial boot source into a sequence of memory writes. It takes one byte per accepted handshake. It first skips the stream's control word. It then parses block headers one after another. Each header carries a block-type flag, a 24-bit destination address and a 16-bit word count. The words of each block go out on a registered write port as 16-bit or 24-bit values, at consecutive addresses.

The flag says four things about a block: whether its words are 16 or 24 bits wide, whether it carries payload bytes or is a zero-fill region, and whether it is the last block of the stream. Zero-fill regions are written one word per cycle and consume no stream bytes. After the last block the loader raises its done output, which tells the boot sequencer to pass control to the first location of page 0. It then accepts nothing further. A reserved flag value stops the loader with an error flag instead. No checksum is carried or checked.

The boot source sets `ws_absent` when the stream lacks the leading wait-state byte, as a UART-fed stream does.

Top module: `boot_loader`

## Requirements
- R1: The stream opens with a control word whose bytes have no effect on any write. It is two bytes long when `ws_absent` is 0 and one byte long when `ws_absent` is 1.
- R2: A header is eight bytes, each 16-bit field sent low byte first. The fields are the flag, address bits 15:0, then address bits 23:16 followed by one ignored padding byte, and finally the word count. Flag bit 0 set means 16-bit words and `wr_wide` = 0. Flag bit 0 clear means 24-bit words and `wr_wide` = 1.
- R3: A 16-bit word arrives as two bytes, low byte first. It is written with `wr_data[23:16]` = 0.
- R4: A 24-bit word arrives as three bytes in the order bits 7:0, 15:8, 23:16.
- R5: When flag bit 2 is set, the block is a zero-fill region. It consumes no payload bytes and writes the value 0 to every one of its locations.
- R6: The first word of a block is written at the header address. Each following word goes to the previous address plus one, with the 24-bit address wrapping.
- R7: A word count of 0 produces no write, and the next byte is parsed as a header (or the loader finishes, if the block is final).
- R8: When flag bit 1 is set, the loader raises `boot_done` once the block's last word is written. `boot_done` stays high, and no byte is accepted and no write occurs after that.
- R9: A 16-bit flag value above 0x0007 is reserved. It raises `boot_err` one cycle after the header's last byte, and nothing from that header is written. `boot_err` stays high and no further byte is accepted.
- R10: `in_ready` is high only while a control, header or payload byte is expected. It is low during zero-fill writing, after done and after an error.
- R11: After reset, `in_ready` is 1 and `wr_en`, `boot_done` and `boot_err` are 0.
- R12: A write appears on the port in the cycle after the byte that completes its word is accepted. A zero-fill write appears in the cycle after its fill cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ws_absent | input | 1 | 1 when the stream has no wait-state byte ahead of the width byte; held static during a boot |
| in_byte | input | 8 | Stream byte |
| in_valid | input | 1 | `in_byte` holds a byte |
| in_ready | output | 1 | The loader takes the byte this cycle if `in_valid` is high |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 24 | Write address |
| wr_data | output | 24 | Write data, right-justified for 16-bit words |
| wr_wide | output | 1 | 1 for a 24-bit word, 0 for a 16-bit word |
| boot_done | output | 1 | Final block completed; control passes to page 0 |
| boot_err | output | 1 | Reserved flag seen; loader halted |

## Verification
The bench sweeps both control-word lengths against all eight legal flags in the second block, with word counts 0 to 3. The first block also varies between 16-bit, 24-bit, data and zero-fill. Destination addresses straddle a 16-bit boundary, so a wrong byte order in the address field or a missing carry into the top address byte shows up. Pseudo-random payload values with irregular byte gaps separate the two-byte and three-byte word assembly. They also expose a misplaced control-word skip, because every later byte would then be misparsed. Reserved flags are tried with bad low bytes and with a non-zero high byte. The stalled ready during zero fill is probed directly, and bytes offered after completion must produce no write.

// File: rtl/bootld_pkg.sv
// Package: shared widths, parser state and block-kind record for the boot loader.
// Assumes the stream geometry of 8-bit bytes, 24-bit addresses and words, and 16-bit counts.
package bootld_pkg;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = 24;
    parameter int DATA_W = 24;
    parameter int CNT_W  = 16;

    typedef enum logic [2:0] {
        ST_CTRL,
        ST_HDR,
        ST_DATA,
        ST_FILL,
        ST_DONE,
        ST_ERR
    } ld_state_e;

    typedef struct packed {
        logic narrow;     // 16-bit words
        logic last_blk;   // final block of the stream
        logic zero;       // zero-fill, no payload bytes
    } blk_kind_t;
endpackage

// File: rtl/bootld_seq.sv
// Module: byte parser. It skips the control word, collects header fields,
// classifies the block and assembles payload words from the stream bytes.
// Assumes the 24-bit address is three bytes and a count is two bytes.
// Emits a step pulse for every word to write (payload or zero fill).
module bootld_seq
    import bootld_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ws_absent,
    input  logic [BW-1:0] in_byte,
    input  logic          in_valid,
    input  logic          last_word,
    output logic          in_ready,
    output logic          hdr_load,
    output logic [AW-1:0] hdr_addr,
    output logic [CW-1:0] hdr_cnt,
    output logic          step,
    output logic          fill,
    output logic [DW-1:0] word_data,
    output blk_kind_t     kind,
    output ld_state_e     state
);
    localparam int IDX_W = 3;
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(7);
    localparam logic [2*BW-1:0]  FLAG_MAX = (2*BW)'(7);

    logic [IDX_W-1:0] byte_idx;
    logic [BW-1:0]    flag_lo, flag_hi, addr_lo, addr_mid, addr_hi, cnt_lo;
    logic [BW-1:0]    d_lo, d_mid;
    logic             take, hdr_end, reserved, word_end;
    logic [IDX_W-1:0] ctrl_last, word_last;

    // Byte acceptance and field decode from the current state.
    always_comb begin
        in_ready  = (state == ST_CTRL) || (state == ST_HDR) || (state == ST_DATA);
        take      = in_valid && in_ready;
        ctrl_last = ws_absent ? IDX_W'(0) : IDX_W'(1);
        word_last = kind.narrow ? IDX_W'(1) : IDX_W'(2);
        hdr_end   = take && (state == ST_HDR) && (byte_idx == HDR_LAST);
        reserved  = {flag_hi, flag_lo} > FLAG_MAX;
        hdr_addr  = {addr_hi, addr_mid, addr_lo};
        hdr_cnt   = {in_byte, cnt_lo};
        hdr_load  = hdr_end && !reserved && (hdr_cnt != '0);
        word_end  = take && (state == ST_DATA) && (byte_idx == word_last);
        fill      = (state == ST_FILL);
        step      = word_end || fill;
        word_data = kind.narrow ? {{BW{1'b0}}, in_byte, d_lo} : {in_byte, d_mid, d_lo};
    end

    // Parser state, byte index and captured header/payload bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CTRL;
            byte_idx <= '0;
            kind     <= '0;
            flag_lo  <= '0;
            flag_hi  <= '0;
            addr_lo  <= '0;
            addr_mid <= '0;
            addr_hi  <= '0;
            cnt_lo   <= '0;
            d_lo     <= '0;
            d_mid    <= '0;
        end else begin
            case (state)
                ST_CTRL: if (take) begin
                    if (byte_idx == ctrl_last) begin
                        state    <= ST_HDR;
                        byte_idx <= '0;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                ST_HDR: if (take) begin
                    case (byte_idx)
                        3'd0:    flag_lo  <= in_byte;
                        3'd1:    flag_hi  <= in_byte;
                        3'd2:    addr_lo  <= in_byte;
                        3'd3:    addr_mid <= in_byte;
                        3'd4:    addr_hi  <= in_byte;
                        3'd6:    cnt_lo   <= in_byte;
                        default: ;
                    endcase
                    if (hdr_end) begin
                        byte_idx      <= '0;
                        kind.narrow   <= flag_lo[0];
                        kind.last_blk <= flag_lo[1];
                        kind.zero     <= flag_lo[2];
                        if (reserved)
                            state <= ST_ERR;
                        else if (hdr_cnt == '0)
                            state <= flag_lo[1] ? ST_DONE : ST_HDR;
                        else
                            state <= flag_lo[2] ? ST_FILL : ST_DATA;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
                ST_DATA: if (take) begin
                    if (word_end) begin
                        byte_idx <= '0;
                        if (last_word)
                            state <= kind.last_blk ? ST_DONE : ST_HDR;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                        if (byte_idx == '0) d_lo  <= in_byte;
                        else                d_mid <= in_byte;
                    end
                end
                ST_FILL: if (last_word)
                    state <= kind.last_blk ? ST_DONE : ST_HDR;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bootld_ctr.sv
// Module: block address and remaining-word counter.
// Loads on a non-empty header; each step advances the address and consumes one word.
// Assumes load and step never coincide (a header is never parsed mid-block).
module bootld_ctr #(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic          last_word
);
    logic [CW-1:0] remain;

    // Flags the word now being produced as the block's last.
    always_comb last_word = (remain == CW'(1));

    // Address and remaining count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            remain   <= load_cnt;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            remain   <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/bootld_wr.sv
// Module: registered memory write port.
// Captures one write per step; zero-fill steps force the data to zero.
// Assumes the address presented with step is the address to write.
module bootld_wr #(
    parameter int AW = 24,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          fill,
    input  logic          narrow,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_wide
);
    // Output register stage for the write strobe and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_wide <= 1'b0;
        end else begin
            wr_en <= step;
            if (step) begin
                wr_addr <= addr;
                wr_data <= fill ? '0 : data;
                wr_wide <= !narrow;
            end
        end
    end
endmodule

// File: rtl/boot_loader.sv
// Module: top of the byte-serial boot stream loader.
// Parses control word, headers and payloads, and drives a registered write port.
// Assumes ws_absent is stable from reset until done or error.
module boot_loader
    import bootld_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ws_absent,
    input  logic [BW-1:0] in_byte,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          wr_wide,
    output logic          boot_done,
    output logic          boot_err
);
    logic          hdr_load, step, fill, last_word;
    logic [AW-1:0] hdr_addr, cur_addr;
    logic [CW-1:0] hdr_cnt;
    logic [DW-1:0] word_data;
    blk_kind_t     kind;
    ld_state_e     state;

    bootld_seq #(.BW(BW), .AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ws_absent(ws_absent),
        .in_byte(in_byte), .in_valid(in_valid), .last_word(last_word),
        .in_ready(in_ready), .hdr_load(hdr_load), .hdr_addr(hdr_addr),
        .hdr_cnt(hdr_cnt), .step(step), .fill(fill), .word_data(word_data),
        .kind(kind), .state(state)
    );

    bootld_ctr #(.AW(AW), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(hdr_load), .load_addr(hdr_addr),
        .load_cnt(hdr_cnt), .step(step), .cur_addr(cur_addr), .last_word(last_word)
    );

    bootld_wr #(.AW(AW), .DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .step(step), .fill(fill), .narrow(kind.narrow),
        .addr(cur_addr), .data(word_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_wide(wr_wide)
    );

    // Terminal status decoded from the parser state.
    always_comb begin
        boot_done = (state == ST_DONE);
        boot_err  = (state == ST_ERR);
    end
endmodule

// File: rtl/boot_loader_chk.sv
// Checker: temporal properties of the loader's ports, bound into boot_loader.
module boot_loader_chk #(
    parameter int AW = 24,
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_wide,
    input logic          boot_done,
    input logic          boot_err
);
    // R10
    halted_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_done || boot_err) |-> !in_ready);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_done |=> boot_done);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_err |=> (boot_err && !boot_done));

    // R8
    no_write_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((boot_done || boot_err) && $past(boot_done || boot_err)) |-> !wr_en);

    // R6
    back_to_back_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1));

    // R5
    back_to_back_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_data == '0));

    // R3
    narrow_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |-> (wr_data[DW-1:16] == '0));
endmodule

bind boot_loader boot_loader_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_wide(wr_wide),
    .boot_done(boot_done), .boot_err(boot_err)
);

// File: tb/tb_boot_loader.sv
module tb_boot_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ws_absent = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready, wr_en, wr_wide, boot_done, boot_err;
    logic [23:0] wr_addr, wr_data;

    always #4 clk = ~clk;

    boot_loader dut (
        .clk(clk), .rst_n(rst_n), .ws_absent(ws_absent), .in_byte(in_byte),
        .in_valid(in_valid), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_wide(wr_wide), .boot_done(boot_done), .boot_err(boot_err)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_n = 0;
    int got_n = 0;
    logic [23:0] ea [64];
    logic [23:0] ed [64];
    logic        ew [64];
    logic        ez [64];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Write monitor: compares every write against the expected list.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (got_n >= exp_n) begin
                chk(1'b0, "R7", "unexpected write", {8'h0, wr_addr}, 32'h0);
            end else begin
                chk(wr_addr == ea[got_n], "R6", "write address", {8'h0, wr_addr}, {8'h0, ea[got_n]});
                chk(wr_data == ed[got_n], ez[got_n] ? "R5" : (ew[got_n] ? "R4" : "R3"),
                    "write data", {8'h0, wr_data}, {8'h0, ed[got_n]});
                chk(wr_wide == ew[got_n], "R2", "word type", {31'h0, wr_wide}, {31'h0, ew[got_n]});
                got_n++;
            end
        end
    end

    function automatic logic [23:0] pval(input int seed, input int i);
        logic [31:0] t;
        t = seed * 32'h9E3779B1 + i * 32'h01234567 + 32'h5A5A5A;
        return t[28:5];
    endfunction

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_n = 0;
        got_n = 0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        bit acc;
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
        in_byte = b;
        in_valid = 1'b1;
        forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic send_ctrl();
        if (!ws_absent) send_byte(8'h07, 0);
        send_byte(8'h01, 1);
    endtask

    // Sends a header and, for payload blocks, its data; records expected writes.
    task automatic send_block(input logic [15:0] flag, input logic [23:0] addr,
                              input logic [15:0] cnt, input int seed);
        logic [23:0] v;
        send_byte(flag[7:0], 0);
        send_byte(flag[15:8], seed % 2);
        send_byte(addr[7:0], 0);
        send_byte(addr[15:8], 0);
        send_byte(addr[23:16], 1);
        send_byte(8'h00, 0);
        send_byte(cnt[7:0], 0);
        send_byte(cnt[15:8], 0);
        if (flag <= 16'd7) begin
            for (int i = 0; i < int'(cnt); i++) begin
                v = pval(seed, i);
                if (flag[0]) v[23:16] = 8'h00;
                if (flag[2]) v = 24'h0;
                ea[exp_n] = addr + 24'(i);
                ed[exp_n] = v;
                ew[exp_n] = !flag[0];
                ez[exp_n] = flag[2];
                exp_n++;
                if (!flag[2]) begin
                    send_byte(v[7:0], (i + seed) % 3);
                    send_byte(v[15:8], (i + seed) % 2);
                    if (!flag[0]) send_byte(v[23:16], 0);
                end
            end
        end
    endtask

    task automatic finish_and_check(input string tag);
        repeat (12) @(negedge clk);
        in_byte = 8'h03;
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(boot_done == 1'b1, "R8", "done", {31'h0, boot_done}, 32'h1);
        chk(boot_err == 1'b0, "R8", "err while done", {31'h0, boot_err}, 32'h0);
        chk(in_ready == 1'b0, "R10", "ready after done", {31'h0, in_ready}, 32'h0);
        chk(got_n == exp_n, tag, "write total", got_n, exp_n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] f1;
        logic [23:0] a2;
        int seed;

        // R11: reset state
        do_reset();
        chk(in_ready == 1'b1, "R11", "ready after reset", {31'h0, in_ready}, 32'h1);
        chk(wr_en == 1'b0, "R11", "wr_en after reset", {31'h0, wr_en}, 32'h0);
        chk(boot_done == 1'b0, "R11", "done after reset", {31'h0, boot_done}, 32'h0);
        chk(boot_err == 1'b0, "R11", "err after reset", {31'h0, boot_err}, 32'h0);

        // Main sweep: R1, R2, R3, R4, R5, R6, R7, R8, R12
        seed = 1;
        for (int u = 0; u < 2; u++) begin
            for (int f = 0; f < 8; f++) begin
                for (int c = 0; c < 4; c++) begin
                    ws_absent = u[0];
                    do_reset();
                    send_ctrl();
                    f1 = {13'h0, c[0], 1'b0, f[0] ^ u[0]};
                    send_block(f1, 24'h00FFFE, 16'd2, seed);
                    a2 = c[1] ? 24'h12FFFF : 24'hABCDE0 + 24'(f);
                    send_block(16'(f), a2, 16'(c), seed + 7);
                    if (f[1] == 1'b0) send_block(16'h0007, 24'h000100, 16'd0, seed);
                    finish_and_check(u[0] ? "R1" : "R7");
                    seed++;
                end
            end
        end

        // R10: ready is low while a zero-fill block is being written
        ws_absent = 1'b0;
        do_reset();
        send_ctrl();
        send_block(16'h0004, 24'h000040, 16'd5, 3);
        chk(in_ready == 1'b0, "R10", "ready during fill", {31'h0, in_ready}, 32'h0);
        send_block(16'h0003, 24'h000050, 16'd2, 4);
        finish_and_check("R5");

        // R9: reserved flags
        for (int k = 0; k < 3; k++) begin
            ws_absent = k[0];
            do_reset();
            send_ctrl();
            send_block(16'h0001, 24'h000200, 16'd1, 9);
            send_block(k == 0 ? 16'h0008 : (k == 1 ? 16'h00FF : 16'h0103),
                       24'h000300, 16'd4, 9);
            repeat (3) @(negedge clk);
            chk(boot_err == 1'b1, "R9", "err on reserved flag", {31'h0, boot_err}, 32'h1);
            chk(boot_done == 1'b0, "R9", "done on reserved flag", {31'h0, boot_done}, 32'h0);
            chk(in_ready == 1'b0, "R9", "ready after error", {31'h0, in_ready}, 32'h0);
            chk(got_n == exp_n, "R9", "writes before error", got_n, exp_n);
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule